// File: doc/BRIEF.md
# Dual Quasi-Bidirectional I/O Port Pair

This block holds the output latches of two 8-bit quasi-bidirectional ports, here called port A and port B. For every pin it produces a pull-down enable, a weak pull-up enable and a one-clock strong pull-up pulse. The pad cells use these to drive the pin low, hold it high weakly, or speed up a rising edge. A pin can be used as an input only while its latch holds 1. A 0 in the latch pulls the pin low.

Software writes a latch through a write strobe. A read returns either the stored latch value, as a read-modify-write instruction needs, or the levels present on the pins, as a plain read needs. Port A bits 0 and 1 have no internal pull-up, because they double as the comparator inputs. Port B bit 6 is not an I/O pin: it reads back the comparator result. The remaining port B pins pass their input levels to the serial receiver, the two external interrupts and the two timer inputs. Port B bit 1 carries the serial transmit data, combined with its latch bit.

Top module: `qb_port_pair`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both latches hold 8'hFF, every pull-down enable is 0 and no strong pull-up pulse is given.
- R2: A write strobe (wr_a or wr_b) loads wdata into that latch at the clock edge. A latch read (rd_latch=1) in a later cycle returns the stored value.
- R3: A pull-down enable is 1 exactly where the pin's driven value is 0. On port A the driven value is the latch bit. Port B bit 6 never pulls down. A pin is never pulled down and up at once.
- R4: The weak pull-up enable equals the driven value on port A bits 2 to 7 and on port B bits 0 to 5 and 7. It is always 0 on port A bits 0 and 1 and on port B bit 6.
- R5: A pin read (rd_latch=0) returns the pin input levels. Port B bit 6 returns cmp_out, both on pin reads and on latch reads.
- R6: The driven value of port B bit 1 is the AND of its latch bit and ser_tx. When ser_tx is 0 that pin is pulled low.
- R7: The strong pull-up pulse is 1 for a pin with an internal pull-up in the cycle after its driven value goes from 0 to 1 at a clock edge. It does not repeat in the next cycle on any pin other than port B bit 1.
- R8: pin_b_in bits 0, 2, 3, 4 and 5 appear on rx_in, ext_int0, ext_int1, tmr0_in and tmr1_in respectively.
- R9: rdata is 0 when neither rd_a nor rd_b is high. When both are high, port A is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_a | input | 1 | Write strobe, port A latch |
| wr_b | input | 1 | Write strobe, port B latch |
| wdata | input | 8 | Write data |
| rd_a | input | 1 | Read select, port A |
| rd_b | input | 1 | Read select, port B |
| rd_latch | input | 1 | 1: read latch, 0: read pins |
| pin_a_in | input | 8 | Pin levels, port A |
| pin_b_in | input | 8 | Pin levels, port B |
| ser_tx | input | 1 | Serial transmit data |
| cmp_out | input | 1 | Comparator result |
| rdata | output | 8 | Read data |
| pd_a | output | 8 | Pull-down enables, port A |
| pu_a | output | 8 | Weak pull-up enables, port A |
| kick_a | output | 8 | Strong pull-up pulses, port A |
| pd_b | output | 8 | Pull-down enables, port B |
| pu_b | output | 8 | Weak pull-up enables, port B |
| kick_b | output | 8 | Strong pull-up pulses, port B |
| rx_in | output | 1 | Serial receive input |
| ext_int0 | output | 1 | External interrupt 0 input |
| ext_int1 | output | 1 | External interrupt 1 input |
| tmr0_in | output | 1 | Timer 0 input |
| tmr1_in | output | 1 | Timer 1 input |

## Verification
The assertions check on every cycle that:
- a write reaches the latch on the next edge;
- no pin is pulled down and up at once;
- the comparator position and the open-drain pins never get a pull-up;
- a low ser_tx forces the transmit pin down;
- a strong pulse follows only a cycle in which the pin was driven low, and lasts a single cycle.

Only the bench's scenarios can show the rest, by comparing every output with a reference model:
- the read data in both read modes, and the read priority;
- that the comparator value appears at bit 6 of port B;
- the routing to the alternate-function inputs;
- the exact cycle in which a pulse appears, including pulses caused by ser_tx.

// File: rtl/qb_port_pair.sv
module qb_port_pair #(
  parameter int W = 8,
  parameter logic [W-1:0] PU_MASK_A = 8'hFC,
  parameter logic [W-1:0] PU_MASK_B = 8'hBF,
  parameter int CMP_BIT  = 6,
  parameter int TX_BIT   = 1,
  parameter int RX_BIT   = 0,
  parameter int INT0_BIT = 2,
  parameter int INT1_BIT = 3,
  parameter int T0_BIT   = 4,
  parameter int T1_BIT   = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_a,
  input  logic         wr_b,
  input  logic [W-1:0] wdata,
  input  logic         rd_a,
  input  logic         rd_b,
  input  logic         rd_latch,
  input  logic [W-1:0] pin_a_in,
  input  logic [W-1:0] pin_b_in,
  input  logic         ser_tx,
  input  logic         cmp_out,
  output logic [W-1:0] rdata,
  output logic [W-1:0] pd_a,
  output logic [W-1:0] pu_a,
  output logic [W-1:0] kick_a,
  output logic [W-1:0] pd_b,
  output logic [W-1:0] pu_b,
  output logic [W-1:0] kick_b,
  output logic         rx_in,
  output logic         ext_int0,
  output logic         ext_int1,
  output logic         tmr0_in,
  output logic         tmr1_in
);

  localparam logic [W-1:0] IO_B = ~(W'(1) << CMP_BIT);

  logic [W-1:0] lat_a, lat_b;
  logic [W-1:0] drv_b;
  logic [W-1:0] drv_qa, drv_qb;
  logic [W-1:0] pin_view_b, lat_view_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a  <= '1;
      lat_b  <= '1;
      drv_qa <= '1;
      drv_qb <= '1;
    end else begin
      if (wr_a) lat_a <= wdata;
      if (wr_b) lat_b <= wdata;
      drv_qa <= lat_a;
      drv_qb <= drv_b;
    end
  end

  always_comb begin
    drv_b = lat_b;
    drv_b[TX_BIT] = lat_b[TX_BIT] & ser_tx;
  end

  assign pd_a   = ~lat_a;
  assign pu_a   = lat_a & PU_MASK_A;
  assign kick_a = lat_a & ~drv_qa & PU_MASK_A;

  assign pd_b   = ~drv_b & IO_B;
  assign pu_b   = drv_b & PU_MASK_B;
  assign kick_b = drv_b & ~drv_qb & PU_MASK_B;

  always_comb begin
    pin_view_b = pin_b_in;
    pin_view_b[CMP_BIT] = cmp_out;
    lat_view_b = lat_b;
    lat_view_b[CMP_BIT] = cmp_out;
  end

  always_comb begin
    if (rd_a)      rdata = rd_latch ? lat_a : pin_a_in;
    else if (rd_b) rdata = rd_latch ? lat_view_b : pin_view_b;
    else           rdata = '0;
  end

  assign rx_in    = pin_b_in[RX_BIT];
  assign ext_int0 = pin_b_in[INT0_BIT];
  assign ext_int1 = pin_b_in[INT1_BIT];
  assign tmr0_in  = pin_b_in[T0_BIT];
  assign tmr1_in  = pin_b_in[T1_BIT];

endmodule

module qb_port_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_a,
  input logic       wr_b,
  input logic [7:0] wdata,
  input logic       ser_tx,
  input logic [7:0] pd_a,
  input logic [7:0] pu_a,
  input logic [7:0] kick_a,
  input logic [7:0] pd_b,
  input logic [7:0] pu_b,
  input logic [7:0] kick_b,
  input logic [7:0] lat_a,
  input logic [7:0] lat_b
);

  assert_latch_load_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a |=> (lat_a == $past(wdata)));

  assert_latch_load_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b |=> (lat_b == $past(wdata)));

  assert_no_fight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pd_a & pu_a) == 8'h00) && ((pd_b & pu_b) == 8'h00));

  assert_no_pullup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_a[1:0] == 2'b00) && !pu_b[6] && !pd_b[6] && (kick_a[1:0] == 2'b00) && !kick_b[6]);

  assert_tx_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_tx |-> pd_b[1]);

  assert_kick_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((kick_a & ~$past(pd_a)) == 8'h00));

  assert_kick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((kick_a & $past(kick_a)) == 8'h00) && ((kick_b & $past(kick_b) & 8'hFD) == 8'h00));

endmodule

bind qb_port_pair qb_port_pair_chk u_chk (.*);

// File: tb/tb_qb_port_pair.sv
module tb_qb_port_pair;
  logic clk = 0, rst_n = 0;
  logic wr_a = 0, wr_b = 0, rd_a = 0, rd_b = 0, rd_latch = 0, ser_tx = 1, cmp_out = 0;
  logic [7:0] wdata = 0, pin_a_in = 8'hFF, pin_b_in = 8'hFF;
  logic [7:0] rdata, pd_a, pu_a, kick_a, pd_b, pu_b, kick_b;
  logic rx_in, ext_int0, ext_int1, tmr0_in, tmr1_in;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] ma, mb, pa, pb;

  always #2 clk = ~clk;

  qb_port_pair dut (.*);

  function automatic logic [7:0] drive_b();
    logic [7:0] d = mb;
    d[1] = mb[1] & ser_tx;
    return d;
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] db = drive_b();
    logic [7:0] er;
    if (rd_a)      er = rd_latch ? ma : pin_a_in;
    else if (rd_b) er = rd_latch ? {mb[7], cmp_out, mb[5:0]} : {pin_b_in[7], cmp_out, pin_b_in[5:0]};
    else           er = 8'h00;
    chk("R3", "pd_a", pd_a, ~ma);
    chk("R4", "pu_a", pu_a, ma & 8'hFC);
    chk("R7", "kick_a", kick_a, ma & ~pa & 8'hFC);
    chk("R6", "pd_b", pd_b, ~db & 8'hBF);
    chk("R4", "pu_b", pu_b, db & 8'hBF);
    chk("R7", "kick_b", kick_b, db & ~pb & 8'hBF);
    chk("R5", "rdata", rdata, er);
    chk("R8", "alt", {3'b0, rx_in, ext_int0, ext_int1, tmr0_in, tmr1_in},
        {3'b0, pin_b_in[0], pin_b_in[2], pin_b_in[3], pin_b_in[4], pin_b_in[5]});
  endtask

  // compare mid-cycle, then advance the model at the edge
  task automatic cycle();
    logic [7:0] db;
    #1 compare();
    @(posedge clk);
    db = drive_b();
    if (rst_n) begin
      pa = ma; pb = db;
      if (wr_a) ma = wdata;
      if (wr_b) mb = wdata;
    end
    @(negedge clk);
  endtask

  task automatic idle(); wr_a = 0; wr_b = 0; rd_a = 0; rd_b = 0; endtask

  initial begin
    #100000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ma = 8'hFF; mb = 8'hFF; pa = 8'hFF; pb = 8'hFF;
    @(negedge clk);
    // R1 reset state, even with strobes active
    wr_a = 1; wdata = 8'h00;
    cycle(); cycle();
    chk("R1", "reset pd_a", pd_a, 8'h00);
    wr_a = 0;
    rst_n = 1;
    cycle();
    chk("R1", "post reset kick_b", kick_b, 8'h00);
    // R2 writes and latch reads
    wr_a = 1; wdata = 8'h5A; cycle(); idle();
    rd_a = 1; rd_latch = 1; pin_a_in = 8'h00; cycle();
    chk("R2", "latch read a", rdata, 8'h5A);
    idle();
    wr_b = 1; wdata = 8'h00; cycle(); idle();
    rd_b = 1; rd_latch = 1; cmp_out = 1; cycle();
    chk("R5", "latch read b bit6 cmp", rdata, 8'h40);
    // R7 rising pulses
    wr_a = 1; wdata = 8'hFF; rd_b = 0; cycle();
    wr_a = 0; wr_b = 1; wdata = 8'hFF; cycle();
    idle(); cycle(); cycle();
    // R6 transmit combinations
    for (int i = 0; i < 6; i++) begin ser_tx = i[0]; cycle(); end
    wr_b = 1; wdata = 8'hFD; cycle(); wr_b = 0;
    ser_tx = 1; cycle(); ser_tx = 0; cycle();
    wr_b = 1; wdata = 8'hFF; cycle(); idle(); ser_tx = 1; cycle(); cycle();
    // R5 pin reads with patterns, R8 routing
    for (int i = 0; i < 40; i++) begin
      pin_a_in = 8'(i * 37 + 5); pin_b_in = 8'(i * 91 + 3); cmp_out = i[1];
      rd_latch = i[0]; rd_a = i[2]; rd_b = i[3]; cycle();
    end
    // R9 both selects and no select
    rd_a = 1; rd_b = 1; rd_latch = 0; pin_a_in = 8'hC3; cycle();
    chk("R9", "priority", rdata, 8'hC3);
    idle(); cycle();
    chk("R9", "no read", rdata, 8'h00);
    // mixed write/read traffic
    for (int i = 0; i < 60; i++) begin
      wr_a = i[0]; wr_b = i[1]; wdata = 8'(i * 53 ^ 8'hA5); ser_tx = i[2] ^ i[0];
      rd_a = i[3]; rd_b = i[4]; rd_latch = i[1]; cmp_out = i[2];
      pin_a_in = 8'(i * 13); pin_b_in = 8'(~i * 29); cycle();
    end
    idle(); cycle();
    // R1 reset again mid-operation
    wr_a = 1; wdata = 8'h00; cycle(); idle();
    rst_n = 0; #1; ma = 8'hFF; mb = 8'hFF; pa = 8'hFF; pb = 8'hFF;
    cycle();
    chk("R1", "re-reset pd_a", pd_a, 8'h00);
    rst_n = 1; cycle(); cycle();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule